// File: doc/BRIEF.md
# Buffered Saturating Line Error Counter Bank

The block keeps two live 16-bit error tallies: one for line code violations and one for bit errors seen by a pseudo-random sequence checker. Each tally has a holding register beside it. The host reads only the holding registers, never the live counts. A latch event copies both live counts into their holding registers and restarts the live counts. A live count stops at all ones and does not wrap. An error strobe that arrives in the cycle of a latch is not dropped. It becomes the first count of the new period.

There are two latch modes. In one-second mode a periodic tick does the latch. In on-demand mode the host asks for a latch with a request strobe, and a done flag reports that the copy has been made. The tick comes from an internal divider of the system clock or from a synchronized external pulse. In both modes every tick sets a sticky interrupt status bit. That bit drives the interrupt line through an enable mask and is cleared by a write-one strobe.

Top module: `err_cnt_bank`

## Requirements
- R1: While `cv_evt_i` is high at a rising clock edge, the code-violation count increments by one. `prbs_evt_i` does the same for the bit-error count. The two counts are independent.
- R2: `cv_buf_o` and `prbs_buf_o` change only on a latch event. Events between latches leave the outputs unchanged.
- R3: A live count that reaches 16'hFFFF stays there until the next latch. A latch of such a count shows 16'hFFFF.
- R4: With `mode_demand_i` = 0, each second tick copies both live counts to the outputs and restarts them. In this mode `latch_req_i` has no effect on the counts, the outputs or `latch_done_o`.
- R5: An event strobe that is high in the latch cycle is counted in the new period, so the next latch shows 1 for it.
- R6: With `mode_demand_i` = 1, a `latch_req_i` strobe copies and restarts both counts. A second tick leaves the outputs and the counts untouched.
- R7: An on-demand latch sets `latch_done_o` on the next cycle. `done_rd_i` clears it. When both happen in the same cycle, the flag ends up set.
- R8: With `ext_sel_i` = 0, `sec_tick_o` is a one-cycle pulse every DIV_TC+1 clock cycles.
- R9: With `ext_sel_i` = 1, each rising edge of `ext_sec_i` gives exactly one tick. The tick appears in the second cycle after the input rises, and holding the input high gives no further ticks.
- R10: Every tick, in either mode, sets `irq_status_o`, and the bit stays set. `irq_o` = `irq_status_o` AND `irq_en_i`. `irq_clr_i` clears the status bit, and a tick in the same cycle wins.
- R11: After reset, the outputs, the done flag and the interrupt status are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cv_evt_i | input | 1 | Code-violation event strobe |
| prbs_evt_i | input | 1 | Sequence bit-error event strobe |
| ext_sel_i | input | 1 | 1: use the external second pulse; 0: use the internal divider |
| ext_sec_i | input | 1 | External second pulse, asynchronous |
| mode_demand_i | input | 1 | 0: latch on tick; 1: latch on host request |
| latch_req_i | input | 1 | Host latch-request write strobe |
| done_rd_i | input | 1 | Host read strobe of the done flag |
| irq_en_i | input | 1 | Interrupt enable mask |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt status |
| cv_buf_o | output | CNT_W | Latched code-violation count |
| prbs_buf_o | output | CNT_W | Latched bit-error count |
| latch_done_o | output | 1 | On-demand latch done flag |
| sec_tick_o | output | 1 | Selected second tick pulse |
| irq_status_o | output | 1 | Sticky tick status |
| irq_o | output | 1 | Masked interrupt |

## Verification
The counters are driven with bursts of different lengths on the two strobes. This shows whether the two channels stay separate, and whether the outputs follow the latch or the live count. One strobe is placed exactly in a latch cycle. That checks the lossless restart, which a plain clear would turn into a zero. A run longer than 65535 events shows whether the count saturates or wraps. Ticks and requests are given in both modes. This checks that only the selected latch source updates the outputs.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_CV   = 0;
  localparam int CH_PRBS = 1;

  typedef enum logic {
    LATCH_ON_TICK   = 1'b0,
    LATCH_ON_DEMAND = 1'b1
  } latch_mode_e;
endpackage

// File: rtl/err_sec_tick.sv
module err_sec_tick #(
  parameter int DIV_TC = 124_999_999
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_sel_i,
  input  logic ext_sec_i,
  output logic tick_o
);
  localparam int DIV_W = (DIV_TC < 2) ? 1 : $clog2(DIV_TC + 1);
  localparam logic [DIV_W-1:0] TC = DIV_W'(DIV_TC);

  logic [DIV_W-1:0] div_q;
  logic             int_tick;
  logic [2:0]       ext_q;   // two sync stages plus edge history
  logic             ext_tick;

  assign int_tick = (div_q == TC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (int_tick) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= {ext_q[1:0], ext_sec_i};
  end

  assign ext_tick = ext_q[1] & ~ext_q[2];
  assign tick_o   = ext_sel_i ? ext_tick : int_tick;
endmodule

// File: rtl/err_sat_counter.sv
module err_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] buf_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q, buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (latch_i) begin
      buf_q <= cnt_q;
      cnt_q <= CNT_W'(evt_i);  // event in latch cycle opens new period
    end else if (evt_i && cnt_q != MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign buf_o = buf_q;
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
  import err_cnt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_TC = 124_999_999
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cv_evt_i,
  input  logic             prbs_evt_i,
  input  logic             ext_sel_i,
  input  logic             ext_sec_i,
  input  logic             mode_demand_i,
  input  logic             latch_req_i,
  input  logic             done_rd_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cv_buf_o,
  output logic [CNT_W-1:0] prbs_buf_o,
  output logic             latch_done_o,
  output logic             sec_tick_o,
  output logic             irq_status_o,
  output logic             irq_o
);
  latch_mode_e                   mode;
  logic                          tick;
  logic                          latch;
  logic                          dem_latch;
  logic                          done_q;
  logic                          irq_q;
  logic [NUM_CH-1:0]             evt;
  logic [NUM_CH-1:0][CNT_W-1:0]  live_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0]  held_cnt;

  assign mode = latch_mode_e'(mode_demand_i);

  err_sec_tick #(.DIV_TC(DIV_TC)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_sel_i(ext_sel_i),
    .ext_sec_i(ext_sec_i),
    .tick_o   (tick)
  );

  assign dem_latch = (mode == LATCH_ON_DEMAND) && latch_req_i;
  assign latch     = (mode == LATCH_ON_TICK) ? tick : latch_req_i;

  assign evt[CH_CV]   = cv_evt_i;
  assign evt[CH_PRBS] = prbs_evt_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    err_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[c]),
      .latch_i(latch),
      .cnt_o  (live_cnt[c]),
      .buf_o  (held_cnt[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        done_q <= 1'b0;
    else if (dem_latch) done_q <= 1'b1;
    else if (done_rd_i) done_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (tick)      irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign cv_buf_o     = held_cnt[CH_CV];
  assign prbs_buf_o   = held_cnt[CH_PRBS];
  assign latch_done_o = done_q;
  assign sec_tick_o   = tick;
  assign irq_status_o = irq_q;
  assign irq_o        = irq_q & irq_en_i;
endmodule

// File: rtl/err_cnt_bank_chk.sv
module err_cnt_bank_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cv_evt_i,
  input logic             mode_demand_i,
  input logic             latch_req_i,
  input logic             latch_i,
  input logic [CNT_W-1:0] cv_cnt_i,
  input logic [CNT_W-1:0] cv_buf_o,
  input logic [CNT_W-1:0] prbs_buf_o,
  input logic             latch_done_o,
  input logic             sec_tick_o,
  input logic             irq_status_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  p_buf_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> ($stable(cv_buf_o) && $stable(prbs_buf_o)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cv_cnt_i == MAX && !latch_i) |=> cv_cnt_i == MAX);

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> cv_buf_o == $past(cv_cnt_i));

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> cv_cnt_i == CNT_W'($past(cv_evt_i)));

  p_demand_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_demand_i && sec_tick_o && !latch_req_i) |-> !latch_i);

  p_done_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_demand_i && latch_req_i) |=> latch_done_o);

  p_tick_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  p_irq_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> irq_status_o);
endmodule

bind err_cnt_bank err_cnt_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cv_evt_i     (cv_evt_i),
  .mode_demand_i(mode_demand_i),
  .latch_req_i  (latch_req_i),
  .latch_i      (latch),
  .cv_cnt_i     (live_cnt[0]),
  .cv_buf_o     (cv_buf_o),
  .prbs_buf_o   (prbs_buf_o),
  .latch_done_o (latch_done_o),
  .sec_tick_o   (sec_tick_o),
  .irq_status_o (irq_status_o)
);

// File: tb/err_cnt_bank_test.sv
module err_cnt_bank_test;
  localparam int CNT_W  = 16;
  localparam int DIV_TC = 49;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cv_evt_i = 0, prbs_evt_i = 0, ext_sel_i = 1, ext_sec_i = 0;
  logic mode_demand_i = 0, latch_req_i = 0, done_rd_i = 0;
  logic irq_en_i = 0, irq_clr_i = 0;
  logic [CNT_W-1:0] cv_buf_o, prbs_buf_o;
  logic latch_done_o, sec_tick_o, irq_status_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  err_cnt_bank #(.CNT_W(CNT_W), .DIV_TC(DIV_TC)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cv_evt_i(cv_evt_i), .prbs_evt_i(prbs_evt_i),
    .ext_sel_i(ext_sel_i), .ext_sec_i(ext_sec_i),
    .mode_demand_i(mode_demand_i), .latch_req_i(latch_req_i),
    .done_rd_i(done_rd_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
    .cv_buf_o(cv_buf_o), .prbs_buf_o(prbs_buf_o),
    .latch_done_o(latch_done_o), .sec_tick_o(sec_tick_o),
    .irq_status_o(irq_status_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_events(input int ncv, input int nprbs);
    int n;
    n = (ncv > nprbs) ? ncv : nprbs;
    for (int i = 0; i < n; i++) begin
      cv_evt_i   = (i < ncv);
      prbs_evt_i = (i < nprbs);
      @(negedge clk);
    end
    cv_evt_i = 0;
    prbs_evt_i = 0;
  endtask

  // external tick; optional cv strobe in the latch cycle
  task automatic ext_tick(input bit cv_at_tick);
    ext_sec_i = 1;
    do @(negedge clk); while (!sec_tick_o);
    cv_evt_i = cv_at_tick;
    @(negedge clk);
    cv_evt_i = 0;
    ext_sec_i = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_latch();
    latch_req_i = 1;
    @(negedge clk);
    latch_req_i = 0;
  endtask

  task automatic t_reset();
    check("R11 cv_buf", cv_buf_o, 0);
    check("R11 prbs_buf", prbs_buf_o, 0);
    check("R11 done", latch_done_o, 0);
    check("R11 irq_status", irq_status_o, 0);
    check("R11 irq", irq_o, 0);
  endtask

  task automatic t_ext_timing();
    int cnt;
    ext_sec_i = 1;
    @(negedge clk);
    check("R9 no tick after 1 cycle", sec_tick_o, 0);
    @(negedge clk);
    check("R9 tick after 2 cycles", sec_tick_o, 1);
    cnt = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cnt += sec_tick_o;
    end
    check("R9 one tick per edge", cnt, 1);
    ext_sec_i = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_one_second();
    mode_demand_i = 0;
    ext_tick(0);
    pulse_events(5, 3);
    check("R2 buffer ignores live count", cv_buf_o, 0);
    ext_tick(1);
    check("R1 R4 cv latched", cv_buf_o, 5);
    check("R1 R4 prbs latched", prbs_buf_o, 3);
    ext_tick(0);
    check("R5 event in latch cycle kept", cv_buf_o, 1);
    check("R4 prbs restarted", prbs_buf_o, 0);
    pulse_events(4, 0);
    host_latch();
    check("R4 request ignored cv", cv_buf_o, 1);
    check("R4 request ignored done", latch_done_o, 0);
    ext_tick(0);
    check("R4 count kept across request", cv_buf_o, 4);
  endtask

  task automatic t_demand();
    mode_demand_i = 1;
    host_latch();
    check("R6 latch of empty count", cv_buf_o, 0);
    check("R7 done set", latch_done_o, 1);
    done_rd_i = 1;
    @(negedge clk);
    done_rd_i = 0;
    check("R7 done cleared by read", latch_done_o, 0);
    pulse_events(2, 7);
    ext_tick(0);
    check("R6 tick ignored cv", cv_buf_o, 0);
    check("R6 tick ignored prbs", prbs_buf_o, 0);
    check("R10 tick sets status in demand mode", irq_status_o, 1);
    latch_req_i = 1;
    done_rd_i = 1;
    @(negedge clk);
    latch_req_i = 0;
    done_rd_i = 0;
    check("R6 cv latched on request", cv_buf_o, 2);
    check("R6 prbs latched on request", prbs_buf_o, 7);
    check("R7 set wins over read", latch_done_o, 1);
  endtask

  task automatic t_saturate();
    mode_demand_i = 1;
    host_latch();
    pulse_events(65540, 2);
    host_latch();
    check("R3 cv saturates", cv_buf_o, 16'hFFFF);
    check("R1 prbs independent", prbs_buf_o, 2);
    host_latch();
    check("R3 restart after saturation", cv_buf_o, 0);
  endtask

  task automatic t_internal();
    int n;
    mode_demand_i = 1;
    ext_sel_i = 0;
    do @(negedge clk); while (!sec_tick_o);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check("R8 tick one cycle wide", sec_tick_o, 0);
    end while (!sec_tick_o && n < 1000);
    check("R8 tick period", n, DIV_TC + 1);
    ext_sel_i = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_irq();
    irq_en_i = 0;
    irq_clr_i = 1;
    @(negedge clk);
    irq_clr_i = 0;
    check("R10 cleared by write-one", irq_status_o, 0);
    ext_tick(0);
    check("R10 set by tick", irq_status_o, 1);
    check("R10 masked", irq_o, 0);
    irq_en_i = 1;
    #1;
    check("R10 enabled", irq_o, 1);
    ext_sec_i = 1;
    do @(negedge clk); while (!sec_tick_o);
    irq_clr_i = 1;
    @(negedge clk);
    irq_clr_i = 0;
    ext_sec_i = 0;
    check("R10 tick wins over clear", irq_status_o, 1);
    irq_clr_i = 1;
    @(negedge clk);
    irq_clr_i = 0;
    check("R10 clear", irq_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_ext_timing();
    t_one_second();
    t_demand();
    t_saturate();
    t_internal();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule